// File: doc/BRIEF.md
# Sub-word Aligned Data Memory

This block is a synchronous data store built from 64-bit rows. A single request port accepts loads and stores of 1, 2, 4 or 8 bytes at a byte address. The low three address bits select the byte position inside the row, and the remaining bits select the row. A narrow store merges its bytes into the row and leaves the other bytes as they were. A load picks its bytes out of the row, moves them down to bit 0 and fills the upper bits with zeros. Each request can ask for the bytes of the value to be reversed over the access width. For a store the reversal happens before the bytes are placed in the row. For a load it happens after they are extracted.

The request side follows valid-only streaming rules. The block applies no back-pressure, so every cycle with `req_valid` high is accepted and completed. The response side has no ready signal. `rsp_valid` pulses for exactly one cycle, one cycle after each load, and the consumer must take the data in that cycle. A request whose byte offset is not a multiple of its width is refused. For such a request `rsp_err` pulses one cycle later, the rows are left unchanged, and a refused load returns zero data.

Top module: `smem_subword`

## Requirements
- R1: The row index is `req_addr >> 3` and the byte offset is `req_addr[2:0]`. A store changes only the row it addresses.
- R2: `req_size` encodes the access width as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. A load returns the row bytes from position offset through offset+width-1. These appear with the lowest byte at `rsp_data[7:0]`, and all higher bits are zero.
- R3: A narrow store writes the low width bytes of `req_wdata` into bytes offset through offset+width-1 of the row. The other bytes of the row keep their values, and `req_wdata` bits at or above width×8 are ignored.
- R4: An 8-byte store at offset 0 replaces the whole row with `req_wdata`.
- R5: With `req_swap` = 1, the byte order of the value is reversed over the access width. This happens before placement on a store and after extraction on a load. A 1-byte access is unaffected.
- R6: An access is legal only when offset mod width = 0. For an illegal access, `rsp_err` is 1 in the following cycle, the rows are unchanged, and an illegal load answers with `rsp_data` = 0.
- R7: `rsp_valid` is 1 exactly in the cycle after each accepted load, and `rsp_data` is registered. Stores produce no `rsp_valid`.
- R8: After reset, every row reads as zero, and `rsp_valid` and `rsp_err` are 0.
- R9: A load to a row in the cycle right after a store to that row returns the merged data.
- R10: Requests are accepted on every cycle with no stall, so back-to-back loads each get their response. A cycle with `req_valid` = 0 gives neither `rsp_valid` nor `rsp_err` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address (row index and byte offset) |
| req_size | input | 2 | Access width code (0..3 = 1, 2, 4, 8 bytes) |
| req_swap | input | 1 | Reverse byte order over the access width |
| req_wdata | input | 64 | Store value, low-aligned |
| rsp_valid | output | 1 | Load response present |
| rsp_data | output | 64 | Load value, zero-extended |
| rsp_err | output | 1 | Previous request was misaligned |

## Verification
The bench builds the block with ROWS = 16, so the address is 7 bits wide and every row can be reached and kept in a small reference model. Width 8 per row is fixed, so all four access widths are covered. Every offset class that is legal or illegal for each width can be driven within a handful of rows. That includes 2-byte, 4-byte and 8-byte requests at odd or unaligned offsets. Back-to-back store/load pairs and idle cycles cover the one-cycle response timing and the read-after-write merge.

// File: rtl/smem_pkg.sv
package smem_pkg;
  localparam int ROW_BYTES = 8;
  localparam int ROW_W     = ROW_BYTES * 8;
  localparam int OFF_W     = $clog2(ROW_BYTES);
  localparam int SHAMT_W   = $clog2(ROW_W);

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } acc_size_e;
endpackage

// File: rtl/smem_lane.sv
module smem_lane
  import smem_pkg::*;
(
  input  logic [OFF_W-1:0]   off,
  input  logic [1:0]         size,
  output logic               aligned,
  output logic [SHAMT_W-1:0] shamt,
  output logic [ROW_W-1:0]   low_mask,
  output logic [ROW_W-1:0]   lane_mask
);
  logic [OFF_W-1:0] width_m1;

  always_comb begin
    unique case (acc_size_e'(size))
      SZ_B1:   width_m1 = OFF_W'(0);
      SZ_B2:   width_m1 = OFF_W'(1);
      SZ_B4:   width_m1 = OFF_W'(3);
      default: width_m1 = OFF_W'(7);
    endcase
  end

  assign aligned = ((off & width_m1) == '0);
  assign shamt   = {off, 3'b000};

  for (genvar b = 0; b < ROW_BYTES; b++) begin : g_mask
    assign low_mask[8*b +: 8] = (b <= int'(width_m1)) ? 8'hFF : 8'h00;
  end

  assign lane_mask = low_mask << shamt;

  // R2: the low mask spans exactly width*8 bits
  always_comb begin
    a_r2_mask_width: assert ($countones(low_mask) == (8 << size));
  end
endmodule

// File: rtl/smem_bswap.sv
module smem_bswap
  import smem_pkg::*;
(
  input  logic [1:0]       size,
  input  logic [ROW_W-1:0] din,
  output logic [ROW_W-1:0] dout
);
  for (genvar b = 0; b < ROW_BYTES; b++) begin : g_byte
    always_comb begin
      int nb;
      nb = 1 << size;
      if (b < nb) dout[8*b +: 8] = din[8*(nb-1-b) +: 8];
      else        dout[8*b +: 8] = 8'h00;
    end
  end
endmodule

// File: rtl/smem_rows.sv
module smem_rows
  import smem_pkg::*;
#(
  parameter int ROWS = 32,
  localparam int IDX_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [ROW_W-1:0] wr_data,
  output logic [ROW_W-1:0] rd_data
);
  logic [ROWS-1:0][ROW_W-1:0] rows_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rows_q <= '0;
    end else if (wr_en) begin
      rows_q[idx] <= wr_data;
    end
  end

  assign rd_data = rows_q[idx];

  // R6: with no write enabled, no row changes
  a_r6_rows_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rows_q));

  // R1: the addressed row takes the written value
  a_r1_row_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rows_q[$past(idx)] == $past(wr_data));
endmodule

// File: rtl/smem_subword.sv
module smem_subword
  import smem_pkg::*;
#(
  parameter int ROWS = 32,
  localparam int IDX_W  = $clog2(ROWS),
  localparam int ADDR_W = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_swap,
  input  logic [ROW_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [ROW_W-1:0]  rsp_data,
  output logic              rsp_err
);
  logic [IDX_W-1:0]   row_idx;
  logic [OFF_W-1:0]   byte_off;
  logic               aligned;
  logic [SHAMT_W-1:0] shamt;
  logic [ROW_W-1:0]   low_mask, lane_mask;
  logic [ROW_W-1:0]   row_cur, row_new;
  logic [ROW_W-1:0]   st_plain, st_swapped, st_val;
  logic [ROW_W-1:0]   ld_plain, ld_swapped, ld_val;
  logic               wr_en;

  logic               rsp_valid_q, rsp_err_q;
  logic [ROW_W-1:0]   rsp_data_q;

  assign row_idx  = req_addr[ADDR_W-1:OFF_W];
  assign byte_off = req_addr[OFF_W-1:0];

  smem_lane u_lane (
    .off       (byte_off),
    .size      (req_size),
    .aligned   (aligned),
    .shamt     (shamt),
    .low_mask  (low_mask),
    .lane_mask (lane_mask)
  );

  // store path: trim, optionally reverse, place into lane, merge
  assign st_plain = req_wdata & low_mask;

  smem_bswap u_st_swap (
    .size (req_size),
    .din  (st_plain),
    .dout (st_swapped)
  );

  assign st_val  = req_swap ? st_swapped : st_plain;
  assign row_new = (row_cur & ~lane_mask) | (st_val << shamt);
  assign wr_en   = req_valid && req_we && aligned;

  smem_rows #(.ROWS(ROWS)) u_rows (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .idx     (row_idx),
    .wr_data (row_new),
    .rd_data (row_cur)
  );

  // load path: isolate lane, bring down to bit 0, optionally reverse
  assign ld_plain = (row_cur & lane_mask) >> shamt;

  smem_bswap u_ld_swap (
    .size (req_size),
    .din  (ld_plain),
    .dout (ld_swapped)
  );

  assign ld_val = req_swap ? ld_swapped : ld_plain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= req_valid && !req_we;
      rsp_err_q   <= req_valid && !aligned;
      if (req_valid && !req_we) rsp_data_q <= aligned ? ld_val : '0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_data  = rsp_data_q;

  // R7: every load is answered in the next cycle
  a_r7_load_answered: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_we |=> rsp_valid);

  // R7 / R10: no response without a load in the previous cycle
  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_we) |=> !rsp_valid);

  // R6: an 8-byte access off offset 0 is refused
  a_r6_dword_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size == 2'd3 && req_addr[2:0] != 3'd0 |=> rsp_err);

  // R6: a 1-byte access never errs
  a_r6_byte_legal: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size == 2'd0 |=> !rsp_err);

  // R6: a refused load carries zero data
  a_r6_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_data == '0);

  // R2: 1-byte loads are zero-extended
  a_r2_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_we && req_size == 2'd0 |=> rsp_data[ROW_W-1:8] == '0);

  // R10: an idle cycle raises no error
  a_r10_idle_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_err);
endmodule

// File: tb/tb_smem_subword.sv
module tb_smem_subword;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS   = 16;
  localparam int ADDR_W = $clog2(ROWS) + 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_we, req_swap;
  logic [ADDR_W-1:0] req_addr;
  logic [1:0]        req_size;
  logic [63:0]       req_wdata;
  logic              rsp_valid, rsp_err;
  logic [63:0]       rsp_data;

  int checks = 0;
  int errors = 0;
  logic [63:0] model [ROWS];

  always #(CLK_PERIOD/2) clk = ~clk;

  smem_subword #(.ROWS(ROWS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_size(req_size), .req_swap(req_swap),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_err(rsp_err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit legal(input logic [ADDR_W-1:0] a, input logic [1:0] sz);
    int nb = 1 << sz;
    return (int'(a[2:0]) % nb) == 0;
  endfunction

  function automatic logic [63:0] rev(input logic [63:0] v, input int nb);
    logic [63:0] o = '0;
    for (int i = 0; i < nb; i++) o[8*i +: 8] = v[8*(nb-1-i) +: 8];
    return o;
  endfunction

  function automatic logic [63:0] ref_load(input logic [ADDR_W-1:0] a,
                                           input logic [1:0] sz, input bit sw);
    int nb = 1 << sz;
    int off = int'(a[2:0]);
    logic [63:0] v = '0;
    if (!legal(a, sz)) return '0;
    for (int i = 0; i < nb; i++) v[8*i +: 8] = model[a[ADDR_W-1:3]][8*(off+i) +: 8];
    return sw ? rev(v, nb) : v;
  endfunction

  task automatic do_store(input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                          input bit sw, input logic [63:0] d, input string req);
    int nb = 1 << sz;
    int off = int'(a[2:0]);
    logic [63:0] d2;
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_size = sz;
    req_swap = sw; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (legal(a, sz)) begin
      d2 = sw ? rev(d, nb) : d;
      for (int i = 0; i < nb; i++) model[a[ADDR_W-1:3]][8*(off+i) +: 8] = d2[8*i +: 8];
    end
    chk(rsp_err == !legal(a, sz), {req, " store err"}, 64'(rsp_err), 64'(!legal(a, sz)));
    chk(rsp_valid == 1'b0, "R7 store gives no response", 64'(rsp_valid), 64'd0);
  endtask

  task automatic do_load(input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                         input bit sw, input string req);
    logic [63:0] exp = ref_load(a, sz, sw);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a; req_size = sz;
    req_swap = sw; req_wdata = '0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R7 load response valid", 64'(rsp_valid), 64'd1);
    chk(rsp_err == !legal(a, sz), {req, " load err"}, 64'(rsp_err), 64'(!legal(a, sz)));
    chk(rsp_data == exp, {req, " load data"}, rsp_data, exp);
  endtask

  task automatic t_reset();
    chk(rsp_valid == 1'b0, "R8 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk(rsp_err == 1'b0, "R8 reset rsp_err", 64'(rsp_err), 64'd0);
    do_load(7'h28, 2'd3, 1'b0, "R8 unwritten row");
    do_load(7'h7C, 2'd2, 1'b0, "R8 unwritten row word");
  endtask

  task automatic t_full();
    do_store(7'h10, 2'd3, 1'b0, 64'h0123_4567_89AB_CDEF, "R4");
    do_load (7'h10, 2'd3, 1'b0, "R4 full row");
    do_store(7'h10, 2'd3, 1'b0, 64'hFEDC_BA98_7654_3210, "R4");
    do_load (7'h10, 2'd3, 1'b0, "R4 full replace");
  endtask

  task automatic t_narrow();
    do_store(7'h18, 2'd3, 1'b0, 64'h1111_2222_3333_4444, "R3");
    do_store(7'h1B, 2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFA5, "R3");
    do_store(7'h1C, 2'd1, 1'b0, 64'hDEAD_BEEF_CAFE_7E57, "R3");
    do_load (7'h18, 2'd3, 1'b0, "R3 merge keeps other bytes");
    do_load (7'h1B, 2'd0, 1'b0, "R2 byte load zero-extended");
    do_load (7'h1C, 2'd1, 1'b0, "R2 half load");
    do_load (7'h1C, 2'd2, 1'b0, "R2 word load upper half");
    do_load (7'h1E, 2'd1, 1'b0, "R2 half load offset 6");
  endtask

  task automatic t_swap();
    do_store(7'h24, 2'd2, 1'b1, 64'h0000_0000_A1B2_C3D4, "R5");
    do_load (7'h24, 2'd2, 1'b0, "R5 swapped store read plain");
    do_load (7'h24, 2'd2, 1'b1, "R5 swapped load");
    do_load (7'h20, 2'd3, 1'b1, "R5 dword swap");
    do_store(7'h21, 2'd0, 1'b1, 64'h0000_0000_0000_005A, "R5");
    do_load (7'h21, 2'd0, 1'b0, "R5 byte swap no effect");
  endtask

  task automatic t_misalign();
    do_store(7'h30, 2'd3, 1'b0, 64'hAAAA_BBBB_CCCC_DDDD, "R6");
    do_store(7'h31, 2'd1, 1'b0, 64'h0000_0000_0000_9999, "R6 misaligned half");
    do_load (7'h30, 2'd3, 1'b0, "R6 row unchanged after misaligned store");
    do_load (7'h32, 2'd2, 1'b0, "R6 misaligned word load");
    do_store(7'h34, 2'd3, 1'b0, 64'h5555_5555_5555_5555, "R6 misaligned dword");
    do_load (7'h30, 2'd3, 1'b0, "R6 row unchanged after dword misalign");
  endtask

  task automatic t_b2b();
    do_store(7'h3A, 2'd1, 1'b0, 64'h0000_0000_0000_4321, "R9");
    do_load (7'h38, 2'd3, 1'b0, "R9 load right after store");
    do_store(7'h40, 2'd3, 1'b0, 64'h7777_7777_7777_7777, "R1");
    do_load (7'h48, 2'd3, 1'b0, "R1 neighbour row untouched");
    do_load (7'h38, 2'd3, 1'b0, "R1 lower row untouched");
  endtask

  task automatic t_idle();
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 idle no response", 64'(rsp_valid), 64'd0);
    chk(rsp_err == 1'b0, "R10 idle no error", 64'(rsp_err), 64'd0);
    do_load(7'h18, 2'd0, 1'b0, "R10 back-to-back load 0");
    do_load(7'h19, 2'd0, 1'b0, "R10 back-to-back load 1");
    do_load(7'h1A, 2'd1, 1'b0, "R10 back-to-back load 2");
  endtask

  initial begin
    for (int i = 0; i < ROWS; i++) model[i] = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0;
    req_size = '0; req_swap = 1'b0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full();
    t_narrow();
    t_swap();
    t_misalign();
    t_b2b();
    t_idle();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule